// File: doc/BRIEF.md
# Bit-Field Insert Unit

This datapath block serves the execute stage of a 32-bit RISC core. It takes the low bits of a source operand and places them into a destination value, starting at a chosen bit position and spanning a chosen number of bits. Every destination bit outside that span is returned unchanged. The start position and the field width each come from a 5-bit immediate. The block produces the updated destination value. It also produces a flag that marks encodings with no legal field.

The field mask is formed by XOR-ing two all-ones words, each shifted left by a different amount. The new value is merged with an XOR into the masked part of the old value, so no per-bit multiplexer is needed.

Two parameters choose variants. `REG_OUT` adds an optional output register with a valid bit. `SHL_STYLE` selects either a plain shift operator or an explicit logarithmic shifter for the three shifts. The datapath width is a parameter.

Top module: `bfi_insert_unit`

## Requirements
- R1: For a legal encoding, result bit `fld_start + k` equals `src_val[k]` for every k from 0 to `fld_width - 1`. Source bits at and above `fld_width` do not affect the result.
- R2: For every encoding, each result bit outside the span from `fld_start` to `fld_start + fld_width - 1` equals the same bit of `dst_val`.
- R3: When `fld_start + fld_width` equals DATA_W, the field reaches the most significant result bit, and all of its bits are loaded from the source.
- R4: When `fld_width` is 0, the result equals `dst_val` and `enc_bad` is 1.
- R5: When `fld_start + fld_width` exceeds DATA_W, the result equals `dst_val` and `enc_bad` is 1.
- R6: For a legal encoding (width nonzero and `fld_start + fld_width <= DATA_W`), `enc_bad` is 0.
- R7: With `REG_OUT = 1`, `result`, `enc_bad` and `out_valid` take the values computed from the inputs sampled at a rising clock edge, and they change at that edge. While `rst_n` is low, all three are 0.
- R8: With `REG_OUT = 0`, the outputs follow the inputs with no clock delay, and `out_valid` equals `in_valid`.
- R9: The result does not depend on `SHL_STYLE`. The plain-operator shifter and the logarithmic shifter give identical outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands are valid this cycle |
| src_val | input | DATA_W | Source operand; the field is taken from its low bits |
| dst_val | input | DATA_W | Current destination value |
| fld_start | input | POS_W | Bit position of the field's least significant bit |
| fld_width | input | POS_W | Field width in bits |
| out_valid | output | 1 | Result is valid |
| result | output | DATA_W | Updated destination value |
| enc_bad | output | 1 | Encoding has no legal field; result equals destination |

## Verification
The bench builds two instances at DATA_W = 32 and runs them side by side. One is registered and uses the logarithmic shifter; the other is combinational and uses the plain operator. Every one of the 1024 start/width pairs is applied with several fixed operand patterns, which covers all legal fields, both illegal classes and every field that ends at the top bit. Random operands then follow. Running both variants in parallel lets the comparison show that the shifter style has no effect and measures the one-cycle offset of the registered stage.

// File: rtl/bfi_pkg.sv
`timescale 1ns/1ps
package bfi_pkg;
   typedef enum logic {
      SHL_BEHAV  = 1'b0,
      SHL_BARREL = 1'b1
   } shl_style_e;

   function automatic bit is_pow2(int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/bfi_shl.sv
`timescale 1ns/1ps
module bfi_shl
   import bfi_pkg::*;
#(
   parameter int         DATA_W = 32,
   parameter int         SH_W   = 6,
   parameter shl_style_e STYLE  = SHL_BARREL
) (
   input  logic [DATA_W-1:0] a,
   input  logic [SH_W-1:0]   sh,
   output logic [DATA_W-1:0] y
);
   generate
      if (STYLE == SHL_BEHAV) begin : g_behav
         assign y = a << sh;
      end else begin : g_barrel
         logic [SH_W:0][DATA_W-1:0] stg;
         assign stg[0] = a;
         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int STEP = 1 << k;
            if (STEP >= DATA_W) begin : g_flush
               assign stg[k+1] = sh[k] ? '0 : stg[k];
            end else begin : g_move
               assign stg[k+1] = sh[k] ? {stg[k][DATA_W-1-STEP:0], {STEP{1'b0}}}
                                       : stg[k];
            end
         end
         assign y = stg[SH_W];
      end
   endgenerate
endmodule

// File: rtl/bfi_mask_gen.sv
`timescale 1ns/1ps
module bfi_mask_gen
   import bfi_pkg::*;
#(
   parameter int         DATA_W = 32,
   parameter int         POS_W  = 5,
   parameter shl_style_e STYLE  = SHL_BARREL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [POS_W-1:0]  fld_start,
   input  logic [POS_W-1:0]  fld_width,
   output logic [DATA_W-1:0] mask_o,
   output logic              illegal_o
);
   localparam int EXT_W = POS_W + 1;

   logic [EXT_W-1:0]  start_x, width_x, end_p1;
   logic [DATA_W-1:0] ones, hi_word, lo_word;

   assign ones    = '1;
   assign start_x = {1'b0, fld_start};
   assign width_x = {1'b0, fld_width};
   assign end_p1  = start_x + width_x;

   assign illegal_o = (fld_width == '0) || (end_p1 > EXT_W'(DATA_W));

   bfi_shl #(.DATA_W(DATA_W), .SH_W(EXT_W), .STYLE(STYLE)) u_hi (
      .a(ones), .sh(end_p1), .y(hi_word)
   );
   bfi_shl #(.DATA_W(DATA_W), .SH_W(EXT_W), .STYLE(STYLE)) u_lo (
      .a(ones), .sh(start_x), .y(lo_word)
   );

   assign mask_o = illegal_o ? '0 : (hi_word ^ lo_word);

   AST_MASK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      !illegal_o |-> ($countones(mask_o) == int'(fld_width))) else $error("mask size"); // R1
   AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      !illegal_o |-> ((((mask_o >> fld_start) + 1'b1) & (mask_o >> fld_start)) == '0)
         && mask_o[fld_start]) else $error("mask shape"); // R1
endmodule

// File: rtl/bfi_merge.sv
`timescale 1ns/1ps
module bfi_merge
   import bfi_pkg::*;
#(
   parameter int         DATA_W = 32,
   parameter int         POS_W  = 5,
   parameter shl_style_e STYLE  = SHL_BARREL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] src_val,
   input  logic [DATA_W-1:0] dst_val,
   input  logic [POS_W-1:0]  fld_start,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] res
);
   logic [DATA_W-1:0] src_sh, delta;

   bfi_shl #(.DATA_W(DATA_W), .SH_W(POS_W + 1), .STYLE(STYLE)) u_src (
      .a(src_val), .sh({1'b0, fld_start}), .y(src_sh)
   );

   assign delta = (src_sh & mask) ^ (dst_val & mask);
   assign res   = dst_val ^ delta;

   AST_KEEP_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      ((res ^ dst_val) & ~mask) == '0) else $error("outside bit changed"); // R2
   AST_FIELD_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      ((res & mask) >> fld_start) == ((src_val << fld_start) & mask) >> fld_start)
      else $error("field content"); // R1
endmodule

// File: rtl/bfi_out_stage.sv
`timescale 1ns/1ps
module bfi_out_stage #(
   parameter int DATA_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              v_i,
   input  logic [DATA_W-1:0] d_i,
   input  logic              bad_i,
   output logic              v_o,
   output logic [DATA_W-1:0] d_o,
   output logic              bad_o
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_o   <= 1'b0;
               d_o   <= '0;
               bad_o <= 1'b0;
            end else begin
               v_o   <= v_i;
               d_o   <= d_i;
               bad_o <= bad_i;
            end
         end
         AST_PIPE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            v_i |=> (v_o && d_o == $past(d_i) && bad_o == $past(bad_i)))
            else $error("pipe step"); // R7
      end else begin : g_comb
         assign v_o   = v_i;
         assign d_o   = d_i;
         assign bad_o = bad_i;
      end
   endgenerate
endmodule

// File: rtl/bfi_insert_unit.sv
`timescale 1ns/1ps
module bfi_insert_unit
   import bfi_pkg::*;
#(
   parameter int         DATA_W    = 32,
   parameter int         POS_W     = $clog2(DATA_W),
   parameter bit         REG_OUT   = 1'b1,
   parameter shl_style_e SHL_STYLE = SHL_BARREL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] src_val,
   input  logic [DATA_W-1:0] dst_val,
   input  logic [POS_W-1:0]  fld_start,
   input  logic [POS_W-1:0]  fld_width,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              enc_bad
);
   generate
      if (!is_pow2(DATA_W) || DATA_W < 8) begin : g_bad_w
         $error("DATA_W must be a power of two of at least 8");
      end
      if (POS_W != $clog2(DATA_W)) begin : g_bad_p
         $error("POS_W must equal clog2(DATA_W)");
      end
   endgenerate

   logic [DATA_W-1:0] mask_c, res_c;
   logic              bad_c;

   bfi_mask_gen #(.DATA_W(DATA_W), .POS_W(POS_W), .STYLE(SHL_STYLE)) u_mask (
      .clk(clk), .rst_n(rst_n), .fld_start(fld_start), .fld_width(fld_width),
      .mask_o(mask_c), .illegal_o(bad_c)
   );

   bfi_merge #(.DATA_W(DATA_W), .POS_W(POS_W), .STYLE(SHL_STYLE)) u_merge (
      .clk(clk), .rst_n(rst_n), .src_val(src_val), .dst_val(dst_val),
      .fld_start(fld_start), .mask(mask_c), .res(res_c)
   );

   bfi_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
      .clk(clk), .rst_n(rst_n), .v_i(in_valid), .d_i(res_c), .bad_i(bad_c),
      .v_o(out_valid), .d_o(result), .bad_o(enc_bad)
   );

   AST_BAD_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
      bad_c |-> (res_c == dst_val)) else $error("illegal changed dst"); // R4
   AST_TOP_BIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bad_c && ({1'b0, fld_start} + {1'b0, fld_width} == (POS_W+1)'(DATA_W)))
      |-> (res_c[DATA_W-1] == src_val[fld_width - 1'b1])) else $error("top bit"); // R3
endmodule

// File: tb/tb_bfi_insert_unit.sv
`timescale 1ns/1ps
module tb_bfi_insert_unit;
   import bfi_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] src_val = '0, dst_val = '0;
   logic [4:0]  fld_start = '0, fld_width = '0;
   logic        ov_r, bad_r, ov_c, bad_c;
   logic [31:0] res_r, res_c;
   int          n_cmp = 0, n_bad = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   bfi_insert_unit #(.DATA_W(32), .REG_OUT(1'b1), .SHL_STYLE(SHL_BARREL)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_val(src_val),
      .dst_val(dst_val), .fld_start(fld_start), .fld_width(fld_width),
      .out_valid(ov_r), .result(res_r), .enc_bad(bad_r)
   );
   bfi_insert_unit #(.DATA_W(32), .REG_OUT(1'b0), .SHL_STYLE(SHL_BEHAV)) dut_c (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_val(src_val),
      .dst_val(dst_val), .fld_start(fld_start), .fld_width(fld_width),
      .out_valid(ov_c), .result(res_c), .enc_bad(bad_c)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h (start=%0d width=%0d)", tag, act, exp,
                  fld_start, fld_width);
      end
   endtask

   function automatic bit legal_enc(int s, int w);
      return (w != 0) && (s + w <= 32);
   endfunction

   function automatic logic [31:0] ref_res(logic [31:0] s_v, logic [31:0] d_v, int s, int w);
      logic [31:0] r = d_v;
      if (legal_enc(s, w))
         for (int i = 0; i < 32; i++)
            if (i >= s && i < s + w) r[i] = s_v[i - s];
      return r;
   endfunction

   function automatic logic [31:0] ref_mask(int s, int w);
      logic [31:0] m = '0;
      if (legal_enc(s, w))
         for (int i = s; i < s + w; i++) m[i] = 1'b1;
      return m;
   endfunction

   task automatic apply(logic [31:0] s_v, logic [31:0] d_v, int s, int w);
      logic [31:0] exp_r, exp_m;
      string       tag;
      @(negedge clk);
      src_val = s_v; dst_val = d_v;
      fld_start = 5'(s); fld_width = 5'(w);
      exp_r = ref_res(s_v, d_v, s, w);
      exp_m = ref_mask(s, w);
      if (w == 0)            tag = "R4";
      else if (s + w > 32)   tag = "R5";
      else if (s + w == 32)  tag = "R3";
      else                   tag = "R1";
      #2;
      chk({tag, " R8 comb result"}, res_c, exp_r);
      chk("R2 outside bits kept", (res_c ^ d_v) & ~exp_m, 32'h0);
      chk(legal_enc(s, w) ? "R6 flag" : {tag, " flag"}, {31'h0, bad_c},
          {31'h0, !legal_enc(s, w)});
      chk("R8 valid passthrough", {31'h0, ov_c}, {31'h0, in_valid});
      @(posedge clk);
      #2;
      chk("R7 registered result", res_r, exp_r);
      chk("R7 registered flag", {31'h0, bad_r}, {31'h0, !legal_enc(s, w)});
      chk("R9 shifter styles agree", res_r, res_c);
   endtask

   initial begin
      #6_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] pat_s [4];
      logic [31:0] pat_d [4];
      pat_s[0] = 32'hFFFF_FFFF; pat_d[0] = 32'h0000_0000;
      pat_s[1] = 32'h0000_0000; pat_d[1] = 32'hFFFF_FFFF;
      pat_s[2] = 32'hA5C3_96E1; pat_d[2] = 32'h5A3C_0F87;
      pat_s[3] = 32'h1234_5679; pat_d[3] = 32'hFEDC_BA98;

      repeat (3) @(posedge clk);
      #2;
      chk("R7 reset result", res_r, 32'h0);
      chk("R7 reset valid", {31'h0, ov_r}, 32'h0);
      chk("R7 reset flag", {31'h0, bad_r}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      in_valid = 1'b1;

      for (int p = 0; p < 4; p++)
         for (int s = 0; s < 32; s++)
            for (int w = 0; w < 32; w++)
               apply(pat_s[p], pat_d[p], s, w);

      for (int n = 0; n < 1500; n++)
         apply($urandom, $urandom, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)));

      @(posedge clk); #2;
      chk("R7 valid after accept", {31'h0, ov_r}, 32'h1);
      @(negedge clk);
      in_valid = 1'b0;
      #2;
      chk("R8 valid drop comb", {31'h0, ov_c}, 32'h0);
      @(posedge clk); #2;
      chk("R7 valid drop registered", {31'h0, ov_r}, 32'h0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule